// File: doc/BRIEF.md
# CPU Clock Source, Sleep and Reset-Cause Controller

This block decides which oscillator feeds the CPU and in which divide ratio. It parks the CPU during sleep and brings it back in an orderly way. It also turns the power-on and watchdog reset requests into one clean system reset, and it keeps a sticky record of which of the two last fired. The controller runs on one always-on fast clock, `clk_i`. The 32 kHz low-power clock arrives as a slow level on `lp_clk_i`, which is synchronised and edge-detected inside the block. The multiplexer on the real clock tree is driven by two gate enables, `int_gate_o` and `ext_gate_o`, and at most one of them is high at any time.

Firmware reaches two byte-wide registers over a plain register port. A write takes effect on the clock edge where `reg_wr_i` is high. A read is combinational from `reg_addr_i`. The port has no valid/ready handshake, because every access completes in one cycle and never stalls.

Register at address 0, clock select:
- bit 0: external source select.
- bit 1: external oscillator enable.
- bits 4:2: divider code. The CPU clock is the source divided by 2^code.

Register at address 1, reset cause:
- bit 0: power-on flag.
- bit 1: watchdog flag.

All other read bits are zero.

After a wake the CPU comes back on the internal oscillator. Firmware must then ask for the external source again.

Top module: `cpu_clk_sleep_ctrl`

## Requirements
- R1: `sys_rst_o` rises as soon as `por_req_i` or `wdr_req_i` is high, with no clock needed. It falls on the second `clk_i` rising edge after both requests are low. `irq_dis_o` is high while `sys_rst_o` is high and for exactly one further cycle.
- R2: After any reset, address 0 reads 0x0C: internal source, external oscillator off, divider code 3 (divide by 8). `cpu_clk_en_o` and `int_gate_o` are high, `ext_gate_o` is low, and `fetch_addr_o` is 0x0000.
- R3: A power-on request sets the power-on flag (address 1, bit 0) and clears the watchdog flag (bit 1). A watchdog request sets bit 1 and leaves bit 0 unchanged.
- R4: Writing 1 to a cause-flag bit at address 1 clears that flag. Writing 0 leaves it unchanged.
- R5: A write of 1 to address 0 bit 0 takes effect only if three conditions hold: the external oscillator enable is already set, the same write keeps that enable at 1, and `ext_stable_i` is high. Otherwise bit 0 reads back 0 and `ext_gate_o` stays low.
- R6: `int_gate_o` and `ext_gate_o` are never high together. When the source changes, the old gate falls first, both stay low for exactly 2 cycles, and then the new gate rises.
- R7: A one-cycle `sleep_req_i` while awake has four effects. On the next edge it clears address 0 bit 0 and drops `cpu_clk_en_o` and `int_osc_run_o`. Both gates are low from the following edge on. The external oscillator enable bit keeps its value.
- R8: After `wake_i`, `int_osc_run_o` rises at once. `cpu_clk_en_o` stays low until the third synchronised rising edge of `lp_clk_i`, and then comes back on the internal gate. Writes to address 0 bit 0 are refused while the block is not awake.
- R9: A `wake_i` pulse during the wake-up count neither restarts nor shortens the count.
- R10: `div_sel_o` always equals the divider code held at address 0, bits 4:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on controller clock (fast internal oscillator) |
| por_req_i | input | 1 | Power-on reset request, active high, asynchronous |
| wdr_req_i | input | 1 | Watchdog reset request, active high |
| lp_clk_i | input | 1 | 32 kHz low-power clock, sampled as data |
| ext_stable_i | input | 1 | External oscillator reports a stable output |
| sleep_req_i | input | 1 | Enter sleep (one-cycle pulse) |
| wake_i | input | 1 | Wake event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 clock select, 1 reset cause |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| cpu_clk_en_o | output | 1 | CPU clock enable after gating |
| int_osc_run_o | output | 1 | Run enable for the internal oscillator |
| ext_osc_en_o | output | 1 | Run enable for the external oscillator |
| int_gate_o | output | 1 | Clock-tree gate for the internal source |
| ext_gate_o | output | 1 | Clock-tree gate for the external source |
| div_sel_o | output | 3 | Divider code, divide by 2^code |
| sys_rst_o | output | 1 | System reset, active high |
| irq_dis_o | output | 1 | Interrupt disable during and just after reset |
| fetch_addr_o | output | 16 | Fetch address presented after reset |

## Verification
Suppose the sleep state machine were stuck or its wake counter slipped. The first visible sign would be `cpu_clk_en_o` rising one 32 kHz edge too early or too late, or never rising. The bench checks this after every individual low-power edge. A fault in the source switcher shows up within a few cycles of the register write, as a gate overlap or a gap of the wrong length, and the bench counts both cycle by cycle. Wrong select or cause bits are caught by the next register read, and wrong reset sequencing by `sys_rst_o` and `irq_dis_o` on the exact edges around the release.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic [1:0] {PW_AWAKE, PW_ASLEEP, PW_RECOVER} pwr_state_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_INT, SRC_EXT} src_e;

  localparam logic ADDR_CLKSEL = 1'b0;
  localparam logic ADDR_CAUSE  = 1'b1;

  localparam int SEL_EXT_BIT = 0;
  localparam int EXT_EN_BIT  = 1;
  localparam int DIV_LSB     = 2;
  localparam int CAUSE_POR   = 0;
  localparam int CAUSE_WDR   = 1;
endpackage

// File: rtl/ccs_rst_sync.sv
module ccs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic req_i,
  output logic rst_o,
  output logic irq_dis_o
);
  logic [STAGES-1:0] sh_q;
  logic              tail_q;

  // Assert at once on the request, release through a shift chain.
  always_ff @(posedge clk_i or posedge req_i) begin
    if (req_i) begin
      sh_q   <= '1;
      tail_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], 1'b0};
      tail_q <= sh_q[STAGES-1];
    end
  end

  assign rst_o     = sh_q[STAGES-1];
  assign irq_dis_o = sh_q[STAGES-1] | tail_q;

  // R1: no clock edge sees a live request without reset out
  p_rst_follows_req_r1: assert property (@(posedge clk_i) req_i |-> rst_o)
    else $error("p_rst_follows_req_r1");
endmodule

// File: rtl/ccs_sleep_fsm.sv
module ccs_sleep_fsm
  import ccs_pkg::*;
#(
  parameter int TICKS = 3,
  parameter int SYNC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       lp_clk_i,
  input  logic       sleep_req_i,
  input  logic       wake_i,
  output pwr_state_e state_o,
  output logic       enter_o
);
  localparam int CNT_W = $clog2(TICKS + 1);

  logic [SYNC:0]    lp_s_q;
  logic             lp_rise;
  pwr_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) lp_s_q <= '0;
    else       lp_s_q <= {lp_s_q[SYNC-1:0], lp_clk_i};
  end
  assign lp_rise = lp_s_q[SYNC-1] & ~lp_s_q[SYNC];

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      st_q  <= PW_AWAKE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        PW_AWAKE:  if (sleep_req_i) st_q <= PW_ASLEEP;
        PW_ASLEEP: if (wake_i) begin
          st_q  <= PW_RECOVER;
          cnt_q <= '0;
        end
        PW_RECOVER: if (lp_rise) begin
          if (cnt_q == CNT_W'(TICKS - 1)) begin
            st_q  <= PW_AWAKE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= PW_AWAKE;
      endcase
    end
  end

  assign state_o = st_q;
  assign enter_o = (st_q == PW_AWAKE) && sleep_req_i;

  // R9: without a low-power edge the count holds, whatever wake does
  p_count_holds_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_q == PW_RECOVER && !lp_rise) |=> (st_q == PW_RECOVER && cnt_q == $past(cnt_q)))
    else $error("p_count_holds_r9");
endmodule

// File: rtl/ccs_clk_switch.sv
module ccs_clk_switch
  import ccs_pkg::*;
#(
  parameter int GAP = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic want_ext_i,
  output logic int_gate_o,
  output logic ext_gate_o
);
  localparam int GAP_W = $clog2(GAP + 1);

  src_e             cur_q, target;
  logic [GAP_W-1:0] gap_q;

  always_comb begin
    if (!run_i)          target = SRC_NONE;
    else if (want_ext_i) target = SRC_EXT;
    else                 target = SRC_INT;
  end

  // Break first, then hold both off for GAP cycles, then make.
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      cur_q <= SRC_INT;
      gap_q <= '0;
    end else if (cur_q != target) begin
      if (cur_q != SRC_NONE) begin
        cur_q <= SRC_NONE;
        gap_q <= '0;
      end else if (gap_q == GAP_W'(GAP - 1)) begin
        cur_q <= target;
        gap_q <= '0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign int_gate_o = (cur_q == SRC_INT);
  assign ext_gate_o = (cur_q == SRC_EXT);

  // R6: the gates never overlap
  p_gate_onehot_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({int_gate_o, ext_gate_o}))
    else $error("p_gate_onehot_r6");
  // R6: a gate rises only when the other was already low
  p_ext_make_after_break_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ext_gate_o) |-> $past(!int_gate_o))
    else $error("p_ext_make_after_break_r6");
  p_int_make_after_break_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(int_gate_o) |-> $past(!ext_gate_o))
    else $error("p_int_make_after_break_r6");
endmodule

// File: rtl/cpu_clk_sleep_ctrl.sv
module cpu_clk_sleep_ctrl
  import ccs_pkg::*;
#(
  parameter int          DIV_W      = 3,
  parameter int          DIV_POR    = 3,
  parameter int          WAKE_TICKS = 3,
  parameter int          SW_GAP     = 2,
  parameter int          RST_STAGES = 2,
  parameter int          LP_SYNC    = 2,
  parameter int          VEC_W      = 16,
  parameter logic [15:0] RESET_VEC  = 16'h0000
) (
  input  logic             clk_i,
  input  logic             por_req_i,
  input  logic             wdr_req_i,
  input  logic             lp_clk_i,
  input  logic             ext_stable_i,
  input  logic             sleep_req_i,
  input  logic             wake_i,
  input  logic             reg_wr_i,
  input  logic             reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             cpu_clk_en_o,
  output logic             int_osc_run_o,
  output logic             ext_osc_en_o,
  output logic             int_gate_o,
  output logic             ext_gate_o,
  output logic [DIV_W-1:0] div_sel_o,
  output logic             sys_rst_o,
  output logic             irq_dis_o,
  output logic [VEC_W-1:0] fetch_addr_o
);
  localparam int USED_W = DIV_LSB + DIV_W;

  logic             rst;
  pwr_state_e       pstate;
  logic             sleep_enter;
  logic             sel_ext_q, ext_en_q;
  logic [DIV_W-1:0] div_q;
  logic             por_flag_q, wdr_flag_q;
  logic             wr_sel, wr_cause;
  logic             awake;

  ccs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i     (clk_i),
    .req_i     (por_req_i | wdr_req_i),
    .rst_o     (rst),
    .irq_dis_o (irq_dis_o)
  );

  ccs_sleep_fsm #(.TICKS(WAKE_TICKS), .SYNC(LP_SYNC)) u_pwr (
    .clk_i       (clk_i),
    .rst_i       (rst),
    .lp_clk_i    (lp_clk_i),
    .sleep_req_i (sleep_req_i),
    .wake_i      (wake_i),
    .state_o     (pstate),
    .enter_o     (sleep_enter)
  );

  ccs_clk_switch #(.GAP(SW_GAP)) u_sw (
    .clk_i      (clk_i),
    .rst_i      (rst),
    .run_i      (pstate != PW_ASLEEP),
    .want_ext_i (sel_ext_q),
    .int_gate_o (int_gate_o),
    .ext_gate_o (ext_gate_o)
  );

  assign awake    = (pstate == PW_AWAKE);
  assign wr_sel   = reg_wr_i && (reg_addr_i == ADDR_CLKSEL);
  assign wr_cause = reg_wr_i && (reg_addr_i == ADDR_CAUSE);

  // Clock-select register; the external pick is guarded.
  always_ff @(posedge clk_i or posedge rst) begin
    if (rst) begin
      sel_ext_q <= 1'b0;
      ext_en_q  <= 1'b0;
      div_q     <= DIV_W'(DIV_POR);
    end else begin
      if (wr_sel) begin
        ext_en_q  <= reg_wdata_i[EXT_EN_BIT];
        div_q     <= reg_wdata_i[DIV_LSB +: DIV_W];
        sel_ext_q <= reg_wdata_i[SEL_EXT_BIT] & reg_wdata_i[EXT_EN_BIT]
                     & ext_en_q & ext_stable_i & awake;
      end
      if (sleep_enter) sel_ext_q <= 1'b0;
    end
  end

  // Cause flags live outside the system reset; only power-on clears them.
  always_ff @(posedge clk_i or posedge por_req_i) begin
    if (por_req_i) begin
      por_flag_q <= 1'b1;
      wdr_flag_q <= 1'b0;
    end else if (wdr_req_i) begin
      wdr_flag_q <= 1'b1;
    end else if (wr_cause) begin
      if (reg_wdata_i[CAUSE_POR]) por_flag_q <= 1'b0;
      if (reg_wdata_i[CAUSE_WDR]) wdr_flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CLKSEL) begin
      reg_rdata_o[SEL_EXT_BIT]         = sel_ext_q;
      reg_rdata_o[EXT_EN_BIT]          = ext_en_q;
      reg_rdata_o[DIV_LSB +: DIV_W]    = div_q;
    end else begin
      reg_rdata_o[CAUSE_POR] = por_flag_q;
      reg_rdata_o[CAUSE_WDR] = wdr_flag_q;
    end
  end

  wire unused_wdata = ^reg_wdata_i[7:USED_W];

  assign cpu_clk_en_o  = awake && (int_gate_o || ext_gate_o);
  assign int_osc_run_o = (pstate != PW_ASLEEP);
  assign ext_osc_en_o  = ext_en_q;
  assign div_sel_o     = div_q;
  assign sys_rst_o     = rst;
  assign fetch_addr_o  = RESET_VEC[VEC_W-1:0];

  // R5: the external pick only lands with the enable set and a stable source
  p_ext_pick_guarded_r5: assert property (@(posedge clk_i) disable iff (rst)
    $rose(sel_ext_q) |-> $past(ext_en_q && ext_stable_i && awake))
    else $error("p_ext_pick_guarded_r5");
  // R7: a sleep request while awake darkens the CPU and drops the pick
  p_sleep_darkens_r7: assert property (@(posedge clk_i) disable iff (rst)
    (awake && sleep_req_i) |=> (!cpu_clk_en_o && !int_osc_run_o && !sel_ext_q))
    else $error("p_sleep_darkens_r7");
  // R3: a watchdog request never wipes the power-on flag
  p_wdr_keeps_por_r3: assert property (@(posedge clk_i) disable iff (por_req_i)
    (wdr_req_i && por_flag_q) |=> por_flag_q)
    else $error("p_wdr_keeps_por_r3");
endmodule

// File: tb/tb_cpu_clk_sleep_ctrl.sv
module tb_cpu_clk_sleep_ctrl;
  logic       clk = 1'b0;
  logic       por_req = 1'b0, wdr_req = 1'b0, lp_clk = 1'b0, ext_stable = 1'b0;
  logic       sleep_req = 1'b0, wake = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cpu_clk_en, int_osc_run, ext_osc_en, int_gate, ext_gate;
  logic [2:0] div_sel;
  logic       sys_rst, irq_dis;
  logic [15:0] fetch_addr;

  int checks = 0, errors = 0, overlap = 0;
  bit done = 1'b0;

  typedef struct { logic addr; logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t sb_q[$];

  always #2 clk = ~clk;

  cpu_clk_sleep_ctrl dut (
    .clk_i(clk), .por_req_i(por_req), .wdr_req_i(wdr_req), .lp_clk_i(lp_clk),
    .ext_stable_i(ext_stable), .sleep_req_i(sleep_req), .wake_i(wake),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .cpu_clk_en_o(cpu_clk_en), .int_osc_run_o(int_osc_run),
    .ext_osc_en_o(ext_osc_en), .int_gate_o(int_gate), .ext_gate_o(ext_gate),
    .div_sel_o(div_sel), .sys_rst_o(sys_rst), .irq_dis_o(irq_dis),
    .fetch_addr_o(fetch_addr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor: pops expected reads at the falling edge.
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      check(reg_rdata == it.exp && reg_addr == it.addr, it.tag, reg_rdata, it.exp);
    end
    if (!sys_rst && int_gate && ext_gate) overlap++;
  end

  task automatic rd(input logic a, input logic [7:0] e, input string tag);
    rd_item_t it;
    reg_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic lp_pulse();
    lp_clk = 1'b1; tick(6);
    lp_clk = 1'b0; tick(6);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not end)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int low_cnt;
    #1 por_req = 1'b1;
    tick(3);
    check(sys_rst && irq_dis, "R1 reset held", {sys_rst, irq_dis}, 3);
    por_req = 1'b0;
    tick(1);
    check(sys_rst == 1'b1, "R1 first edge after release", sys_rst, 1);
    tick(1);
    check(sys_rst == 1'b0 && irq_dis == 1'b1, "R1 second edge", {sys_rst, irq_dis}, 1);
    tick(1);
    check(irq_dis == 1'b0, "R1 irq disable tail", irq_dis, 0);

    // R2 defaults
    rd(1'b0, 8'h0C, "R2 clock select default");
    check(div_sel == 3'd3, "R10 divider default", div_sel, 3);
    check(fetch_addr == 16'h0000, "R2 fetch address", fetch_addr, 0);
    check(cpu_clk_en && int_gate && !ext_gate, "R2 running internal",
          {cpu_clk_en, int_gate, ext_gate}, 6);
    rd(1'b1, 8'h01, "R3 power-on flag");

    // R4 write-one-to-clear
    wr(1'b1, 8'h00);
    rd(1'b1, 8'h01, "R4 zero write keeps flag");
    wr(1'b1, 8'h01);
    rd(1'b1, 8'h00, "R4 one write clears flag");

    // R5 refusal cases
    ext_stable = 1'b1;
    wr(1'b0, 8'h0D);
    rd(1'b0, 8'h0C, "R5 refused without enable");
    ext_stable = 1'b0;
    wr(1'b0, 8'h0E);
    wr(1'b0, 8'h0F);
    rd(1'b0, 8'h0E, "R5 refused while unstable");
    check(!ext_gate && ext_osc_en, "R5 gate stays low", {ext_gate, ext_osc_en}, 1);

    // R6 accepted switch and gap length
    ext_stable = 1'b1;
    wr(1'b0, 8'h0F);
    low_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!int_gate && !ext_gate) low_cnt++;
    end
    #1;
    check(low_cnt == 2, "R6 break gap cycles", low_cnt, 2);
    check(ext_gate && !int_gate && cpu_clk_en, "R6 on external",
          {ext_gate, int_gate, cpu_clk_en}, 5);
    rd(1'b0, 8'h0F, "R5 accepted pick");

    // R7 sleep
    sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
    check(!cpu_clk_en && !int_osc_run, "R7 dark after sleep", {cpu_clk_en, int_osc_run}, 0);
    tick(2);
    check(!int_gate && !ext_gate, "R7 gates off", {int_gate, ext_gate}, 0);
    rd(1'b0, 8'h0E, "R7 pick cleared, enable kept");
    wr(1'b0, 8'h0F);
    rd(1'b0, 8'h0E, "R8 pick refused while asleep");

    // R8 / R9 wake
    wake = 1'b1; tick(1); wake = 1'b0;
    tick(2);
    check(int_osc_run && !cpu_clk_en, "R8 oscillator restarts, CPU gated",
          {int_osc_run, cpu_clk_en}, 2);
    lp_clk = 1'b1; tick(3);
    wake = 1'b1; tick(1); wake = 1'b0;
    tick(2); lp_clk = 1'b0; tick(6);
    check(!cpu_clk_en, "R8 gated after one edge", cpu_clk_en, 0);
    lp_pulse();
    check(!cpu_clk_en, "R9 still gated after two edges", cpu_clk_en, 0);
    lp_clk = 1'b1; tick(6);
    check(cpu_clk_en && int_gate && !ext_gate, "R9 resumes on third edge",
          {cpu_clk_en, int_gate, ext_gate}, 6);
    lp_clk = 1'b0; tick(2);
    rd(1'b0, 8'h0E, "R8 resumes on internal");

    // R10 divider follow
    wr(1'b0, 8'h16);
    check(div_sel == 3'd5, "R10 divider follows register", div_sel, 5);

    // Watchdog reset
    wdr_req = 1'b1; tick(1);
    check(sys_rst && irq_dis, "R1 watchdog asserts reset", {sys_rst, irq_dis}, 3);
    tick(1); wdr_req = 1'b0; tick(4);
    rd(1'b0, 8'h0C, "R2 defaults after watchdog");
    check(fetch_addr == 16'h0000, "R2 fetch address after watchdog", fetch_addr, 0);
    rd(1'b1, 8'h02, "R3 watchdog flag only");

    // Power-on after watchdog, then watchdog on top of power-on
    por_req = 1'b1; tick(2); por_req = 1'b0; tick(4);
    rd(1'b1, 8'h01, "R3 power-on clears watchdog flag");
    wdr_req = 1'b1; tick(2); wdr_req = 1'b0; tick(4);
    rd(1'b1, 8'h03, "R3 watchdog keeps power-on flag");
    wr(1'b1, 8'h02);
    rd(1'b1, 8'h01, "R4 clear only watchdog flag");

    check(overlap == 0, "R6 gates never overlap", overlap, 0);
    tick(2);
    check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule